// File: doc/BRIEF.md
# Low-Power Mode Sequencer with Wake-Up Arbitration

This controller moves a small SoC between normal operation and six sleep states. From deepest to lightest they are backup, backup with DRAM retained, ULP2, ULP1, ULP0 and idle. Software picks one of the four deep states with a one-cycle request strobe. The processor reaches the two light states by asserting its wait-for-interrupt line. For the four deep states the block first asks the external DRAM controller to enter self-refresh and waits for its acknowledge. Only then does it drop the supply enables and the processor clock gate.

Each sleep state has its own set of wake sources. The two backup states sample their sources only on a slow-clock tick. ULP2 and ULP1 pass their sources through a synchronizer and react to them on any cycle. The light states react to any enabled interrupt. When a wake occurs, the block records the cause in a sticky register that software clears by writing ones. It then releases self-refresh, waits for the exit acknowledge, and releases the processor. On the way out it forces the main clock onto the internal RC oscillator (after a deep state) or the bus clock onto the slow clock (after ULP0).

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the block is in the run phase: all supply enables, `cpu_clk_en` and `cpu_release` are 1; `sr_req`, `busy`, `main_osc_rc`, `bus_clk_slow` and `wake_cause` are 0.
- R2: `pm_phase` encodes run=0, self-refresh entry=1, sleep=2, self-refresh exit=3. `sleep_mode` encodes backup=0, backup-with-DRAM=1, ULP2=2, ULP1=3, ULP0=4, idle=5. In run, `mode_req_valid` with `mode_req_sel` 0..3 selects the state of the same code. `cpu_wfi` selects ULP0 when `wfi_deep`=1 and idle otherwise. A request and `cpu_wfi` in the same cycle resolve to the request.
- R3: A deep-state entry raises `sr_req` and holds every supply and the clock gate on until `sr_ack` is seen high.
- R4: Leaving a deep state drops `sr_req`. `cpu_release` stays 0 until `sr_ack` has returned low.
- R5: In sleep, {core, cpu, DRAM I/O} supply enables are {0,0,0} in backup, {0,0,1} in backup-with-DRAM, {1,0,1} in ULP2, and {1,1,1} in ULP1, ULP0 and idle.
- R6: In sleep, `cpu_clk_en` is 0 for the four deep states and 1 for ULP0 and idle. `cpu_release` is 1 only in run.
- R7: Cause bits are RTC alarm [0], RTT alarm [1], wake pin [2], security wake pin [3], backup I/O pins [7:4], any GPIO [8], USB resume [9], enabled interrupt [10]. The backup states wake only on bits 0..7. ULP2/ULP1 wake only on bits 0,1,8,9. ULP0/idle wake only on bit 10.
- R8: In the two backup states an asserted source wakes the block only in a cycle where `slow_tick` is 1.
- R9: ULP2/ULP1 sources pass a `SYNC_STAGES` synchronizer and act on any cycle. An interrupt counts only where `irq_pending & irq_en` is non-zero, and it moves the block from sleep to run at the next clock edge.
- R10: After a wake from a deep state `main_osc_rc`=1. After a wake from ULP0 `bus_clk_slow`=1. After a wake from idle both are 0. The values hold until the next accepted entry, which clears them.
- R11: The qualifying sources are latched into `wake_cause` only while it is zero. Set bits hold until written 1 on `cause_clr`.
- R12: Requests and `cpu_wfi` outside the run phase are ignored.
- R13: A qualifying wake during self-refresh entry aborts the entry. The block goes through self-refresh exit back to run without cutting any supply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| mode_req_valid | input | 1 | Software deep-state request strobe |
| mode_req_sel | input | 2 | Requested deep state (0..3) |
| cpu_wfi | input | 1 | Processor wait-for-interrupt |
| wfi_deep | input | 1 | 1: wait-for-interrupt enters ULP0, 0: idle |
| rtc_alarm | input | 1 | RTC alarm wake source |
| rtt_alarm | input | 1 | RTT alarm wake source |
| wake_pin | input | 1 | General wake pin |
| sec_wake_pin | input | 1 | Security-event wake pin |
| bkio_pin | input | 4 | Backup-domain I/O wake pins |
| gpio_wake | input | N_GPIO | GPIO wake lines |
| usb_resume | input | 1 | USB resume signalling |
| irq_pending | input | N_IRQ | Pending interrupt lines |
| irq_en | input | N_IRQ | Interrupt enables |
| sr_ack | input | 1 | DRAM self-refresh acknowledge |
| cause_clr | input | 11 | Write-1-to-clear strobe for wake_cause |
| sup_core_en | output | 1 | Core supply enable |
| sup_cpu_en | output | 1 | Processor supply enable |
| sup_dram_io_en | output | 1 | DRAM I/O supply enable |
| cpu_clk_en | output | 1 | Processor clock gate enable |
| cpu_release | output | 1 | Processor allowed to run |
| sr_req | output | 1 | DRAM self-refresh request |
| main_osc_rc | output | 1 | Main clock forced to RC oscillator |
| bus_clk_slow | output | 1 | Bus clock forced to slow clock |
| wake_cause | output | 11 | Sticky wake cause |
| pm_phase | output | 2 | Sequencer phase |
| sleep_mode | output | 3 | Current or last target state |
| busy | output | 1 | Sequence in progress |

## Verification
The checker assumes that the DRAM side behaves as a handshake: `sr_ack` rises only while `sr_req` is high and falls only after `sr_req` has dropped. The supply-cut and processor-release properties depend on this. The bench meets the assumption with a small DRAM model that copies `sr_req` onto `sr_ack` one cycle later. That model can be frozen, but only in a state it had legitimately reached, to stretch entry or exit. Wake sources are held until the block is back in run. `slow_tick` is only ever a single-cycle pulse, which matches the one-sample-per-tick behaviour the backup states rely on.

// File: rtl/pwr_mode_pkg.sv
// Shared types and per-state policy for the low-power sequencer.
// Assumes cause bit layout: 0 rtc, 1 rtt, 2 wake pin, 3 security pin,
// 7:4 backup I/O, 8 any GPIO, 9 USB resume, 10 interrupt.
package pwr_mode_pkg;

    typedef enum logic [2:0] {
        PM_BACKUP    = 3'd0,
        PM_BACKUP_SR = 3'd1,
        PM_ULP2      = 3'd2,
        PM_ULP1      = 3'd3,
        PM_ULP0      = 3'd4,
        PM_IDLE      = 3'd5
    } pm_mode_e;

    typedef enum logic [1:0] {
        PH_RUN      = 2'd0,
        PH_SR_ENTRY = 2'd1,
        PH_SLEEP    = 2'd2,
        PH_SR_EXIT  = 2'd3
    } pm_phase_e;

    typedef enum logic [1:0] {
        OVR_NONE = 2'd0,
        OVR_RC   = 2'd1,
        OVR_SLOW = 2'd2
    } clk_ovr_e;

    localparam int N_BKIO   = 4;
    localparam int EXT_W    = 6 + N_BKIO;
    localparam int CAUSE_W  = EXT_W + 1;
    localparam int IRQ_BIT  = EXT_W;

    localparam logic [CAUSE_W-1:0] MASK_BACKUP = 11'b000_1111_1111;
    localparam logic [CAUSE_W-1:0] MASK_ULP    = 11'b011_0000_0011;
    localparam logic [CAUSE_W-1:0] MASK_LIGHT  = 11'b100_0000_0000;

    // True for the states that need DRAM in self-refresh.
    function automatic logic needs_sr(input pm_mode_e m);
        return (m == PM_BACKUP) || (m == PM_BACKUP_SR) ||
               (m == PM_ULP2)   || (m == PM_ULP1);
    endfunction

    // True for the states whose sources are sampled on the slow tick.
    function automatic logic tick_sampled(input pm_mode_e m);
        return (m == PM_BACKUP) || (m == PM_BACKUP_SR);
    endfunction

    // Wake-source mask per state.
    function automatic logic [CAUSE_W-1:0] wake_mask(input pm_mode_e m);
        logic [CAUSE_W-1:0] r;
        case (m)
            PM_BACKUP, PM_BACKUP_SR: r = MASK_BACKUP;
            PM_ULP2, PM_ULP1:        r = MASK_ULP;
            default:                 r = MASK_LIGHT;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwr_wake_filter.sv
// Wake filter: synchronizes external sources, masks them by the armed
// state and gates tick-sampled states with slow_tick.
// Assumes irq inputs are already in the clk domain; slow_tick is a pulse.
module pwr_wake_filter
    import pwr_mode_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               armed,
    input  pm_mode_e           mode,
    input  logic               slow_tick,
    input  logic [EXT_W-1:0]   ext_raw,
    input  logic               irq_hit,
    output logic [CAUSE_W-1:0] qual,
    output logic               wake
);
    logic [EXT_W-1:0] sync_q [SYNC_STAGES];
    logic [EXT_W-1:0] ext_gated;
    logic [CAUSE_W-1:0] raw_all;

    // First synchronizer stage captures the asynchronous sources.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= '0;
        else        sync_q[0] <= ext_raw;
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
        // Further synchronizer stages.
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[s] <= '0;
            else        sync_q[s] <= sync_q[s-1];
        end
    end

    // Tick gating for backup states, masking and arming.
    always_comb begin
        ext_gated = sync_q[SYNC_STAGES-1];
        if (tick_sampled(mode) && !slow_tick) ext_gated = '0;
        raw_all = {irq_hit, ext_gated};
        qual    = armed ? (raw_all & wake_mask(mode)) : '0;
        wake    = |qual;
    end
endmodule

// File: rtl/pwr_seq_fsm.sv
// Entry/exit sequencer: accepts requests in run, handles the DRAM
// self-refresh handshake, sleeps, aborts or exits on wake.
// Assumes sr_ack follows sr_req as a four-phase handshake.
module pwr_seq_fsm
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic [1:0] req_sel,
    input  logic      wfi,
    input  logic      wfi_deep,
    input  logic      wake,
    input  logic      sr_ack,
    output pm_phase_e phase,
    output pm_mode_e  target,
    output logic      sr_req,
    output logic      seq_start,
    output logic      sleep_exit
);
    pm_phase_e phase_d;
    pm_mode_e  target_d;

    // Next-phase and target selection.
    always_comb begin
        phase_d  = phase;
        target_d = target;
        unique case (phase)
            PH_RUN: begin
                if (req_valid) begin
                    target_d = pm_mode_e'({1'b0, req_sel});
                    phase_d  = PH_SR_ENTRY;
                end else if (wfi) begin
                    target_d = wfi_deep ? PM_ULP0 : PM_IDLE;
                    phase_d  = PH_SLEEP;
                end
            end
            PH_SR_ENTRY: begin
                if (wake)        phase_d = PH_SR_EXIT;
                else if (sr_ack) phase_d = PH_SLEEP;
            end
            PH_SLEEP: begin
                if (wake) phase_d = needs_sr(target) ? PH_SR_EXIT : PH_RUN;
            end
            PH_SR_EXIT: begin
                if (!sr_ack) phase_d = PH_RUN;
            end
            default: phase_d = PH_RUN;
        endcase
    end

    // Phase and target registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_RUN;
            target <= PM_IDLE;
        end else begin
            phase  <= phase_d;
            target <= target_d;
        end
    end

    // Handshake and event strobes.
    always_comb begin
        sr_req     = (phase == PH_SR_ENTRY) ||
                     ((phase == PH_SLEEP) && needs_sr(target));
        seq_start  = (phase == PH_RUN) && (req_valid || wfi);
        sleep_exit = (phase == PH_SLEEP) && wake;
    end
endmodule

// File: rtl/pwr_wake_cause.sv
// Sticky wake-cause register: latches the qualifying sources of the
// first wake while empty; bits clear on write-1, a latch wins a clear.
module pwr_wake_cause
    import pwr_mode_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wake,
    input  logic [CAUSE_W-1:0] qual,
    input  logic [CAUSE_W-1:0] clr,
    output logic [CAUSE_W-1:0] cause
);
    logic [CAUSE_W-1:0] cause_d;

    // Clear then conditionally latch.
    always_comb begin
        cause_d = cause & ~clr;
        if (wake && (cause == '0)) cause_d = cause_d | qual;
    end

    // Cause storage.
    always_ff @(posedge clk) begin
        if (!rst_n) cause <= '0;
        else        cause <= cause_d;
    end
endmodule

// File: rtl/pwr_out_dec.sv
// Output decode: supply enables and clock gate from phase and target,
// plus the clock-source override held from a wake until the next entry.
module pwr_out_dec
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pm_phase_e phase,
    input  pm_mode_e  mode,
    input  logic      seq_start,
    input  logic      sleep_exit,
    output logic      sup_core_en,
    output logic      sup_cpu_en,
    output logic      sup_dram_io_en,
    output logic      cpu_clk_en,
    output logic      cpu_release,
    output logic      main_osc_rc,
    output logic      bus_clk_slow
);
    clk_ovr_e ovr;
    logic     in_sleep;

    // Supply and clock gating per sleep state.
    always_comb begin
        in_sleep       = (phase == PH_SLEEP);
        sup_core_en    = !(in_sleep && tick_sampled(mode));
        sup_dram_io_en = !(in_sleep && (mode == PM_BACKUP));
        sup_cpu_en     = !(in_sleep && (tick_sampled(mode) || mode == PM_ULP2));
        cpu_clk_en     = !(in_sleep && needs_sr(mode));
        cpu_release    = (phase == PH_RUN);
        main_osc_rc    = (ovr == OVR_RC);
        bus_clk_slow   = (ovr == OVR_SLOW);
    end

    // Clock-source override register.
    always_ff @(posedge clk) begin
        if (!rst_n)          ovr <= OVR_NONE;
        else if (seq_start)  ovr <= OVR_NONE;
        else if (sleep_exit) begin
            if (needs_sr(mode))       ovr <= OVR_RC;
            else if (mode == PM_ULP0) ovr <= OVR_SLOW;
            else                      ovr <= OVR_NONE;
        end
    end
endmodule

// File: rtl/pwr_mode_seq.sv
// Top: low-power mode sequencer with per-state wake arbitration.
// Assumes all inputs except the wake sources are in the clk domain.
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int N_GPIO      = 8,
    parameter int N_IRQ       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              mode_req_valid,
    input  logic [1:0]        mode_req_sel,
    input  logic              cpu_wfi,
    input  logic              wfi_deep,
    input  logic              rtc_alarm,
    input  logic              rtt_alarm,
    input  logic              wake_pin,
    input  logic              sec_wake_pin,
    input  logic [3:0]        bkio_pin,
    input  logic [N_GPIO-1:0] gpio_wake,
    input  logic              usb_resume,
    input  logic [N_IRQ-1:0]  irq_pending,
    input  logic [N_IRQ-1:0]  irq_en,
    input  logic              sr_ack,
    input  logic [10:0]       cause_clr,
    output logic              sup_core_en,
    output logic              sup_cpu_en,
    output logic              sup_dram_io_en,
    output logic              cpu_clk_en,
    output logic              cpu_release,
    output logic              sr_req,
    output logic              main_osc_rc,
    output logic              bus_clk_slow,
    output logic [10:0]       wake_cause,
    output logic [1:0]        pm_phase,
    output logic [2:0]        sleep_mode,
    output logic              busy
);
    pm_phase_e          phase;
    pm_mode_e           target;
    logic               wake;
    logic               seq_start;
    logic               sleep_exit;
    logic [CAUSE_W-1:0] qual;
    logic [EXT_W-1:0]   ext_raw;
    logic               irq_hit;
    logic               armed;

    // Source gathering in cause-bit order.
    always_comb begin
        ext_raw = {usb_resume, |gpio_wake, bkio_pin, sec_wake_pin,
                   wake_pin, rtt_alarm, rtc_alarm};
        irq_hit = |(irq_pending & irq_en);
        armed   = (phase == PH_SR_ENTRY) || (phase == PH_SLEEP);
    end

    pwr_wake_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
        .clk(clk), .rst_n(rst_n), .armed(armed), .mode(target),
        .slow_tick(slow_tick), .ext_raw(ext_raw), .irq_hit(irq_hit),
        .qual(qual), .wake(wake)
    );

    pwr_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(mode_req_valid),
        .req_sel(mode_req_sel), .wfi(cpu_wfi), .wfi_deep(wfi_deep),
        .wake(wake), .sr_ack(sr_ack), .phase(phase), .target(target),
        .sr_req(sr_req), .seq_start(seq_start), .sleep_exit(sleep_exit)
    );

    pwr_wake_cause u_cause (
        .clk(clk), .rst_n(rst_n), .wake(wake), .qual(qual),
        .clr(cause_clr), .cause(wake_cause)
    );

    pwr_out_dec u_out (
        .clk(clk), .rst_n(rst_n), .phase(phase), .mode(target),
        .seq_start(seq_start), .sleep_exit(sleep_exit),
        .sup_core_en(sup_core_en), .sup_cpu_en(sup_cpu_en),
        .sup_dram_io_en(sup_dram_io_en), .cpu_clk_en(cpu_clk_en),
        .cpu_release(cpu_release), .main_osc_rc(main_osc_rc),
        .bus_clk_slow(bus_clk_slow)
    );

    // Status outputs.
    always_comb begin
        pm_phase   = phase;
        sleep_mode = target;
        busy       = (phase != PH_RUN);
    end
endmodule

// File: rtl/pwr_mode_seq_chk.sv
// Checker for pwr_mode_seq, attached by bind. Assumes sr_ack is a
// well-behaved handshake response to sr_req.
module pwr_mode_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sr_ack,
    input logic [10:0] cause_clr,
    input logic        sup_core_en,
    input logic        sup_cpu_en,
    input logic        sup_dram_io_en,
    input logic        cpu_release,
    input logic        main_osc_rc,
    input logic        bus_clk_slow,
    input logic [10:0] wake_cause,
    input logic [1:0]  pm_phase,
    input logic [2:0]  sleep_mode
);
    // R3: core supply drops only with self-refresh acknowledged.
    a_r3_core_cut_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sup_core_en) |-> sr_ack);

    // R3: processor supply drops only with self-refresh acknowledged.
    a_r3_cpu_cut_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sup_cpu_en) |-> sr_ack);

    // R4: processor is released only once the exit acknowledge is low.
    a_r4_release_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_release) |-> !sr_ack);

    // R5: supplies nest: DRAM I/O off implies core off implies cpu off.
    a_r5_supply_nesting: assert property (@(posedge clk) disable iff (!rst_n)
        (!sup_dram_io_en |-> !sup_core_en) and (!sup_core_en |-> !sup_cpu_en));

    // R10: at most one clock-source override at a time.
    a_r10_override_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_osc_rc && bus_clk_slow));

    // R11: cause bits not written 1 stay set.
    a_r11_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(wake_cause) & ~$past(cause_clr)) & ~wake_cause) == 11'd0));

    // R12: the target state does not move outside the run phase.
    a_r12_target_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_phase != 2'd0) |=> $stable(sleep_mode));
endmodule

bind pwr_mode_seq pwr_mode_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sr_ack(sr_ack), .cause_clr(cause_clr),
    .sup_core_en(sup_core_en), .sup_cpu_en(sup_cpu_en),
    .sup_dram_io_en(sup_dram_io_en), .cpu_release(cpu_release),
    .main_osc_rc(main_osc_rc), .bus_clk_slow(bus_clk_slow),
    .wake_cause(wake_cause), .pm_phase(pm_phase), .sleep_mode(sleep_mode)
);

// File: tb/sim_pwr_mode_seq.sv
module sim_pwr_mode_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slow_tick = 0, mode_req_valid = 0, cpu_wfi = 0, wfi_deep = 0;
    logic [1:0] mode_req_sel = 0;
    logic rtc_alarm = 0, rtt_alarm = 0, wake_pin = 0, sec_wake_pin = 0, usb_resume = 0;
    logic [3:0] bkio_pin = 0;
    logic [7:0] gpio_wake = 0;
    logic [15:0] irq_pending = 0, irq_en = '1;
    logic sr_ack = 0;
    logic ack_en = 1;
    logic [10:0] cause_clr = 0;
    logic sup_core_en, sup_cpu_en, sup_dram_io_en, cpu_clk_en, cpu_release, sr_req;
    logic main_osc_rc, bus_clk_slow, busy;
    logic [10:0] wake_cause;
    logic [1:0] pm_phase;
    logic [2:0] sleep_mode;
    int n_chk = 0, n_fail = 0;
    logic core_dropped = 0;

    always #5 clk = ~clk;

    pwr_mode_seq u0 (.*);

    // DRAM controller model: acknowledge follows request one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n)      sr_ack <= 1'b0;
        else if (ack_en) sr_ack <= sr_req;
    end

    always @(negedge clk) if (!sup_core_en) core_dropped = 1'b1;

    typedef struct packed {
        logic       by_wfi;
        logic [2:0] mode;
        logic [3:0] src;
        logic [2:0] sup;   // {core, cpu, dram io}
        logic       cgate;
        logic [1:0] ovr;   // 0 none, 1 rc, 2 slow
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 3'd0, 4'd0,  3'b000, 1'b0, 2'd1},
        '{1'b0, 3'd1, 4'd6,  3'b001, 1'b0, 2'd1},
        '{1'b0, 3'd2, 4'd8,  3'b101, 1'b0, 2'd1},
        '{1'b0, 3'd3, 4'd9,  3'b111, 1'b0, 2'd1},
        '{1'b0, 3'd0, 4'd3,  3'b000, 1'b0, 2'd1},
        '{1'b1, 3'd4, 4'd10, 3'b111, 1'b1, 2'd2},
        '{1'b1, 3'd5, 4'd10, 3'b111, 1'b1, 2'd0},
        '{1'b0, 3'd3, 4'd1,  3'b111, 1'b0, 2'd1}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_src(input int idx, input logic v);
        case (idx)
            0: rtc_alarm = v;
            1: rtt_alarm = v;
            2: wake_pin = v;
            3: sec_wake_pin = v;
            4, 5, 6, 7: bkio_pin[idx-4] = v;
            8: gpio_wake[0] = v;
            9: usb_resume = v;
            default: irq_pending[0] = v;
        endcase
    endtask

    task automatic wait_phase(input int ph, input int lim, input bit ticks, input string req);
        bit hit = 0;
        for (int i = 0; i < lim && !hit; i++) begin
            slow_tick = ticks && (i % 4 == 3);
            @(negedge clk);
            if (pm_phase == ph[1:0]) hit = 1;
        end
        slow_tick = 0;
        chk(req, "phase reached", int'(pm_phase), ph);
    endtask

    task automatic idle_cycles(input int n, input bit ticks);
        for (int i = 0; i < n; i++) begin
            slow_tick = ticks && (i % 4 == 3);
            @(negedge clk);
        end
        slow_tick = 0;
    endtask

    task automatic clear_cause();
        cause_clr = '1;
        @(negedge clk);
        cause_clr = '0;
    endtask

    task automatic enter(input bit by_wfi, input int mode);
        if (by_wfi) begin
            cpu_wfi = 1; wfi_deep = (mode == 4);
        end else begin
            mode_req_valid = 1; mode_req_sel = mode[1:0];
        end
        @(negedge clk);
        cpu_wfi = 0; mode_req_valid = 0;
    endtask

    function automatic int ovr_now();
        return bus_clk_slow ? 2 : (main_osc_rc ? 1 : 0);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "phase", int'(pm_phase), 0);
        chk("R1", "supplies/gate/release", int'({sup_core_en, sup_cpu_en, sup_dram_io_en, cpu_clk_en, cpu_release}), 5'h1f);
        chk("R1", "sr_req/busy/ovr", int'({sr_req, busy, main_osc_rc, bus_clk_slow}), 0);
        chk("R1", "cause", int'(wake_cause), 0);

        // Vector walk: R2 R5 R6 R7 R9 R10 R3 R4
        foreach (VECS[k]) begin
            clear_cause();
            enter(VECS[k].by_wfi, int'(VECS[k].mode));
            wait_phase(2, 40, 0, "R3");
            chk("R2", "sleep_mode", int'(sleep_mode), int'(VECS[k].mode));
            chk("R5", "supplies", int'({sup_core_en, sup_cpu_en, sup_dram_io_en}), int'(VECS[k].sup));
            chk("R6", "cpu_clk_en", int'(cpu_clk_en), int'(VECS[k].cgate));
            set_src(int'(VECS[k].src), 1'b1);
            wait_phase(0, 60, VECS[k].mode <= 3'd1, "R7");
            chk("R7", "cause", int'(wake_cause), 1 << VECS[k].src);
            chk("R10", "override", ovr_now(), int'(VECS[k].ovr));
            chk("R4", "released/req", int'({cpu_release, sr_req}), 2'b10);
            set_src(int'(VECS[k].src), 1'b0);
            idle_cycles(4, 0);
        end

        // R11: cause not empty, new wake does not overwrite
        enter(1'b1, 4);
        wait_phase(2, 10, 0, "R11");
        set_src(10, 1'b1);
        wait_phase(0, 10, 0, "R11");
        set_src(10, 1'b0);
        chk("R11", "sticky cause", int'(wake_cause), 11'h002);
        cause_clr = 11'h002; @(negedge clk); cause_clr = 0;
        chk("R11", "w1c", int'(wake_cause), 0);

        // R7/R8: backup masks GPIO/USB and needs the slow tick
        enter(1'b0, 0);
        wait_phase(2, 20, 0, "R8");
        gpio_wake[0] = 1; usb_resume = 1;
        idle_cycles(30, 1);
        chk("R7", "backup ignores gpio/usb", int'(pm_phase), 2);
        gpio_wake[0] = 0; usb_resume = 0;
        wake_pin = 1;
        idle_cycles(20, 0);
        chk("R8", "no wake without tick", int'(pm_phase), 2);
        wait_phase(0, 40, 1, "R8");
        chk("R8", "cause wake pin", int'(wake_cause), 11'h004);
        wake_pin = 0; idle_cycles(4, 0); clear_cause();

        // R9: masked interrupt ignored, enabled one wakes next edge
        irq_en = '0; irq_pending[0] = 1;
        enter(1'b1, 5);
        idle_cycles(20, 0);
        chk("R9", "masked irq ignored", int'(pm_phase), 2);
        irq_en = '1;
        @(negedge clk);
        chk("R9", "irq wake in one edge", int'(pm_phase), 0);
        chk("R9", "cause irq", int'(wake_cause), 11'h400);
        irq_pending[0] = 0; clear_cause();

        // R2: request beats wfi in the same cycle
        mode_req_valid = 1; mode_req_sel = 2'd2; cpu_wfi = 1; wfi_deep = 1;
        @(negedge clk);
        mode_req_valid = 0; cpu_wfi = 0;
        wait_phase(2, 20, 0, "R2");
        chk("R2", "request wins", int'(sleep_mode), 2);
        gpio_wake[0] = 1;
        wait_phase(0, 20, 0, "R2");
        gpio_wake[0] = 0; idle_cycles(4, 0); clear_cause();

        // R12 and R4: ignored requests in sleep, exit waits for ack low
        enter(1'b0, 3);
        wait_phase(2, 20, 0, "R12");
        mode_req_valid = 1; mode_req_sel = 2'd0; cpu_wfi = 1;
        @(negedge clk);
        mode_req_valid = 0; cpu_wfi = 0;
        @(negedge clk);
        chk("R12", "target kept", int'(sleep_mode), 3);
        chk("R12", "core stays on", int'(sup_core_en), 1);
        ack_en = 0;
        usb_resume = 1;
        wait_phase(3, 20, 0, "R4");
        idle_cycles(10, 0);
        chk("R4", "held in exit", int'({pm_phase, cpu_release, sr_req}), 4'b1100);
        ack_en = 1;
        wait_phase(0, 10, 0, "R4");
        chk("R4", "released", int'(cpu_release), 1);
        usb_resume = 0; idle_cycles(4, 0); clear_cause();

        // R13 and R3: no ack, wake during entry aborts without cuts
        ack_en = 0; core_dropped = 0;
        enter(1'b0, 2);
        idle_cycles(10, 0);
        chk("R3", "waiting for ack", int'({pm_phase, sup_cpu_en}), 3'b011);
        gpio_wake[0] = 1;
        wait_phase(0, 20, 0, "R13");
        chk("R13", "no supply cut", int'(core_dropped | !sup_cpu_en), 0);
        chk("R13", "cause gpio", int'(wake_cause), 11'h100);
        gpio_wake[0] = 0; ack_en = 1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule